// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block is the pin-side front end of a small microcontroller's external interrupt logic. It watches eight input pins. Each pin passes through a synchroniser and is sampled on the CPU clock. Each channel then tests its samples against a 2-bit sense code chosen at run time: low level, any change, falling edge or rising edge.

A change between two successive samples that matches the channel's code sets a sticky flag. Software clears that flag by writing one to it, or the CPU side clears it with a per-channel acknowledge pulse. A channel in low-level mode never uses its flag. Its request follows the synchronised pin directly and drops as soon as the pin returns high.

A request reaches the pending vector only when the channel's enable bit and the global interrupt enable are both set. A single request line is the OR of the pending vector. The block works from the pin value alone, so firmware that drives a pin as an output can raise a software interrupt on that pin. Software is expected to clear a channel's enable bit before it changes that channel's sense code.

Each channel's flag is a two-state machine:
- `CH_IDLE`: the flag is clear.
- `CH_HELD`: the flag is set.

It moves between these states on three named transitions:
- `T_CAPTURE`: from `CH_IDLE` to `CH_HELD` on a matching event.
- `T_RELEASE`: from `CH_HELD` to `CH_IDLE` on a clear request with no event in the same cycle.
- `T_FLUSH`: from `CH_HELD` to `CH_IDLE` while the channel is in low-level mode.

An event in `CH_HELD` keeps the flag in `CH_HELD`.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the following are all zero: both sense registers, the enable register, the flag register, `pending_o` and `irq_o`.
- R2: The register map is as follows.
  - Address 0 holds channels 3..0 and address 1 holds channels 7..4.
  - In each sense register, channel n uses bits [2(n mod 4)+1 : 2(n mod 4)], so the highest channel of the register sits in the top bits.
  - Address 2 is the enable register, with bit n for channel n.
  - Address 3 reads the flags, with bit n for channel n.
  - Each register reads back what was last written to it.
- R3: With sense code 00 (low level), the channel's request is high while the synchronised pin is low. It appears on `pending_o` two clock edges after the pin falls and drops two edges after the pin rises.
- R4: With sense code 01 (any change), a rising or a falling pin sets the channel's flag. The flag appears three clock edges after the pin change.
- R5: With sense code 10 (falling), a falling pin sets the flag and a rising pin does not.
- R6: With sense code 11 (rising), a rising pin sets the flag and a falling pin does not.
- R7: `pending_o[n]` is high only when enable bit n and `glb_ie_i` are both 1. Flags are still set while a channel is disabled, and they can be read at address 3.
- R8: A write to address 3 clears every flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R9: A one-cycle pulse on `ack_i[n]` clears flag n.
- R10: When an event and a clear (write or acknowledge) arrive in the same cycle, the flag stays set.
- R11: `irq_o` is 1 exactly when any bit of `pending_o` is 1.
- R12: In edge or change mode, a pin pulse that lasts one clock period still sets the flag.
- R13: With sense code 00, the flag bit stays 0 whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_CH | External interrupt pins, asynchronous |
| glb_ie_i | input | 1 | Global interrupt enable |
| ack_i | input | NUM_CH | Per-channel flag acknowledge pulses |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Register write strobe |
| bus_wdata_i | input | NUM_CH | Register write data |
| bus_rdata_o | output | NUM_CH | Register read data, combinational |
| pending_o | output | NUM_CH | Enabled requests per channel |
| irq_o | output | 1 | OR of all pending requests |

## Verification
The bench builds the block with its default of eight channels and a two-stage synchroniser. With eight channels both sense registers are populated, so the bench can check channel placement against the top-bits ordering in each of them. With two synchroniser stages the latencies are fixed: two edges from pin to level request and three edges from pin to flag. Those fixed counts let the bench land an acknowledge in exactly the cycle that carries an event, and let it shape a single-clock pulse that is still caught.

// File: rtl/eisc_pkg.sv
package eisc_pkg;

    localparam int BUS_AW = 2;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_HELD = 1'b1
    } ch_state_e;

endpackage

// File: rtl/eisc_sync.sv
module eisc_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eisc_channel.sv
module eisc_channel (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_i,
    input  eisc_pkg::sense_e mode_i,
    input  logic            clr_i,
    output logic            evt_o,
    output logic            lvl_o,
    output logic            flag_o
);
    import eisc_pkg::*;

    ch_state_e state_q, state_d;
    logic      prev_q;
    logic      rise, fall;

    // previous sample tracks every clock, enabled or not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    assign rise = smp_i & ~prev_q;
    assign fall = ~smp_i & prev_q;

    always_comb begin
        unique case (mode_i)
            SENSE_LOW:  evt_o = 1'b0;
            SENSE_ANY:  evt_o = rise | fall;
            SENSE_FALL: evt_o = fall;
            SENSE_RISE: evt_o = rise;
            default:    evt_o = 1'b0;
        endcase
    end

    assign lvl_o = (mode_i == SENSE_LOW) & ~smp_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // transitions: T_CAPTURE, T_RELEASE, T_FLUSH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (evt_o) state_d = CH_HELD;
            CH_HELD: begin
                if (evt_o)                        state_d = CH_HELD;
                else if (mode_i == SENSE_LOW)     state_d = CH_IDLE;
                else if (clr_i)                   state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CH_HELD: flag_o = 1'b1;
            default: flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/eisc_regs.sv
module eisc_regs #(
    parameter int NUM_CH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [eisc_pkg::BUS_AW-1:0]   addr_i,
    input  logic                          we_i,
    input  logic [NUM_CH-1:0]             wdata_i,
    input  logic [NUM_CH-1:0]             flags_i,
    output logic [2*NUM_CH-1:0]           mode_o,
    output logic [NUM_CH-1:0]             en_o,
    output logic [NUM_CH-1:0]             clr_o,
    output logic [NUM_CH-1:0]             rdata_o
);
    import eisc_pkg::*;

    localparam int DATA_W    = NUM_CH;
    localparam int MODE_REGS = 2;
    localparam logic [BUS_AW-1:0] A_EN   = BUS_AW'(MODE_REGS);
    localparam logic [BUS_AW-1:0] A_FLAG = BUS_AW'(MODE_REGS + 1);

    logic [2*NUM_CH-1:0] mode_q;
    logic [NUM_CH-1:0]   en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            en_q   <= '0;
        end else if (we_i) begin
            for (int k = 0; k < MODE_REGS; k++) begin
                if (addr_i == BUS_AW'(k)) mode_q[k*DATA_W +: DATA_W] <= wdata_i;
            end
            if (addr_i == A_EN) en_q <= wdata_i;
        end
    end

    assign clr_o  = (we_i && addr_i == A_FLAG) ? wdata_i : '0;
    assign mode_o = mode_q;
    assign en_o   = en_q;

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < MODE_REGS; k++) begin
            if (addr_i == BUS_AW'(k)) rdata_o = mode_q[k*DATA_W +: DATA_W];
        end
        if (addr_i == A_EN)   rdata_o = en_q;
        if (addr_i == A_FLAG) rdata_o = flags_i;
    end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CH-1:0]           pin_i,
    input  logic                        glb_ie_i,
    input  logic [NUM_CH-1:0]           ack_i,
    input  logic [eisc_pkg::BUS_AW-1:0] bus_addr_i,
    input  logic                        bus_we_i,
    input  logic [NUM_CH-1:0]           bus_wdata_i,
    output logic [NUM_CH-1:0]           bus_rdata_o,
    output logic [NUM_CH-1:0]           pending_o,
    output logic                        irq_o
);
    import eisc_pkg::*;

    logic [NUM_CH-1:0]   sync_q;
    logic [2*NUM_CH-1:0] mode_q;
    logic [NUM_CH-1:0]   en_q;
    logic [NUM_CH-1:0]   clr_wr;
    logic [NUM_CH-1:0]   evt_v;
    logic [NUM_CH-1:0]   lvl_v;
    logic [NUM_CH-1:0]   lvl_mode_v;
    logic [NUM_CH-1:0]   flag_v;

    eisc_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_q)
    );

    eisc_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr_i),
        .we_i    (bus_we_i),
        .wdata_i (bus_wdata_i),
        .flags_i (flag_v),
        .mode_o  (mode_q),
        .en_o    (en_q),
        .clr_o   (clr_wr),
        .rdata_o (bus_rdata_o)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        sense_e ch_mode;
        assign ch_mode       = sense_e'(mode_q[2*n +: 2]);
        assign lvl_mode_v[n] = (ch_mode == SENSE_LOW);

        eisc_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_i  (sync_q[n]),
            .mode_i (ch_mode),
            .clr_i  (clr_wr[n] | ack_i[n]),
            .evt_o  (evt_v[n]),
            .lvl_o  (lvl_v[n]),
            .flag_o (flag_v[n])
        );
    end

    assign pending_o = en_q & {NUM_CH{glb_ie_i}} & (lvl_v | flag_v);
    assign irq_o     = |pending_o;
endmodule

// File: rtl/eisc_checker.sv
module eisc_checker #(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glb_ie,
    input logic [NUM_CH-1:0] en,
    input logic [NUM_CH-1:0] pending,
    input logic              irq,
    input logic [NUM_CH-1:0] flags,
    input logic [NUM_CH-1:0] evt,
    input logic [NUM_CH-1:0] lvl_mode,
    input logic [NUM_CH-1:0] smp,
    input logic [NUM_CH-1:0] ack
);
    assert_gate_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_ie |-> (pending == '0 && !irq));

    assert_gate_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~en) == '0);

    assert_irq_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pending) == 0) |-> !irq);

    assert_level_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & lvl_mode & smp) == '0);

    assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~$past(flags) & ~$past(evt)) == '0);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack) & ~$past(evt) & ~$past(lvl_mode) & flags) == '0);

    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evt) & ~flags) == '0);

    assert_level_noflag_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lvl_mode) & flags) == '0);
endmodule

bind ext_irq_sense eisc_checker #(.NUM_CH(NUM_CH)) u_eisc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_ie   (glb_ie_i),
    .en       (en_q),
    .pending  (pending_o),
    .irq      (irq_o),
    .flags    (flag_v),
    .evt      (evt_v),
    .lvl_mode (lvl_mode_v),
    .smp      (sync_q),
    .ack      (ack_i)
);

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] pin;
    logic           glb_ie;
    logic [NCH-1:0] ack;
    logic [1:0]     bus_addr;
    logic           bus_we;
    logic [NCH-1:0] bus_wdata;
    logic [NCH-1:0] bus_rdata;
    logic [NCH-1:0] pending;
    logic           irq;

    int total = 0;
    int bad   = 0;
    logic [15:0] mode_sh = '0;

    always #5 clk = ~clk;

    ext_irq_sense i_ext_irq_sense (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .glb_ie_i    (glb_ie),
        .ack_i       (ack),
        .bus_addr_i  (bus_addr),
        .bus_we_i    (bus_we),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .pending_o   (pending),
        .irq_o       (irq)
    );

    // vector: {ch[2:0], mode[1:0], from, to, expected flag}
    localparam logic [7:0] VEC [9] = '{
        {3'd0, 2'b01, 1'b1, 1'b0, 1'b1},   // R4 change, falling
        {3'd1, 2'b01, 1'b0, 1'b1, 1'b1},   // R4 change, rising
        {3'd2, 2'b10, 1'b1, 1'b0, 1'b1},   // R5 falling taken
        {3'd3, 2'b10, 1'b0, 1'b1, 1'b0},   // R5 rising ignored
        {3'd4, 2'b11, 1'b0, 1'b1, 1'b1},   // R6 rising taken
        {3'd5, 2'b11, 1'b1, 1'b0, 1'b0},   // R6 falling ignored
        {3'd6, 2'b01, 1'b1, 1'b1, 1'b0},   // R4 no change, no flag
        {3'd7, 2'b00, 1'b1, 1'b0, 1'b0},   // R13 level leaves flag clear
        {3'd7, 2'b10, 1'b1, 1'b0, 1'b1}    // R2 upper register field
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        tick(1);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_mode(input int ch, input logic [1:0] m);
        mode_sh[2*ch +: 2] = m;
        wr(2'(ch / 4), mode_sh[(ch / 4) * 8 +: 8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; pin = '1; glb_ie = 1'b0; ack = '0;
        bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        tick(3);
        rst_n = 1'b1;
        tick(4);

        // R1 reset state
        chk("R1 pending", pending, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 register", d, 8'h00);
        end

        // R2 readback
        wr(2'd0, 8'hE4); wr(2'd1, 8'h1B); wr(2'd2, 8'h00);
        rd(2'd0, d); chk("R2 sense low reg", d, 8'hE4);
        rd(2'd1, d); chk("R2 sense high reg", d, 8'h1B);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00);
        mode_sh = '0;

        // table walk: R4 R5 R6 R13 R2
        for (int i = 0; i < 9; i++) begin
            int ch;
            ch = int'(VEC[i][7:5]);
            set_mode(ch, VEC[i][4:3]);
            pin[ch] = VEC[i][2];
            tick(4);
            wr(2'd3, 8'hFF);
            pin[ch] = VEC[i][1];
            tick(3);
            rd(2'd3, d);
            chk($sformatf("R4/R5/R6/R13 vector %0d flag", i), {7'd0, d[ch]}, {7'd0, VEC[i][0]});
        end
        pin = '1;
        tick(4);
        wr(2'd3, 8'hFF);

        // R3 level mode, R11 request line, R7 global gate
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); mode_sh = '0;
        wr(2'd2, 8'h20);
        glb_ie = 1'b1;
        pin[5] = 1'b0;
        tick(2);
        chk("R3 level pending", pending, 8'h20);
        chk("R11 irq high", {7'd0, irq}, 8'h01);
        glb_ie = 1'b0;
        #1;
        chk("R7 global gate pending", pending, 8'h00);
        chk("R11 irq low", {7'd0, irq}, 8'h00);
        glb_ie = 1'b1;
        pin[5] = 1'b1;
        tick(2);
        chk("R3 level release", pending, 8'h00);

        // R7 flag set while disabled
        wr(2'd2, 8'h00);
        set_mode(1, 2'b11);
        pin[1] = 1'b0;
        tick(4);
        wr(2'd3, 8'hFF);
        pin[1] = 1'b1;
        tick(3);
        rd(2'd3, d); chk("R7 flag while masked", d, 8'h02);
        chk("R7 masked pending", pending, 8'h00);
        wr(2'd2, 8'h02);
        chk("R7 enabled pending", pending, 8'h02);

        // R8 write-one-to-clear
        wr(2'd3, 8'h00);
        rd(2'd3, d); chk("R8 zero write keeps", d, 8'h02);
        wr(2'd3, 8'h02);
        rd(2'd3, d); chk("R8 one write clears", d, 8'h00);
        chk("R8 pending after clear", pending, 8'h00);

        // R9 acknowledge pulse
        pin[1] = 1'b0; tick(3);
        pin[1] = 1'b1; tick(3);
        rd(2'd3, d); chk("R9 flag before ack", d, 8'h02);
        ack = 8'h02; tick(1); ack = 8'h00;
        rd(2'd3, d); chk("R9 ack clears", d, 8'h00);

        // R10 event and clear in the same cycle
        set_mode(1, 2'b01);
        pin[1] = 1'b0; tick(3);
        rd(2'd3, d); chk("R10 flag preset", d, 8'h02);
        pin[1] = 1'b1;
        tick(2);
        ack = 8'h02; tick(1); ack = 8'h00;
        rd(2'd3, d); chk("R10 event beats ack", d, 8'h02);
        chk("R10 pending kept", pending, 8'h02);
        wr(2'd3, 8'h02);
        rd(2'd3, d); chk("R10 later clear", d, 8'h00);

        // R12 one-period pulse in rising mode
        wr(2'd2, 8'h00);
        set_mode(4, 2'b11);
        pin[4] = 1'b0; tick(4);
        wr(2'd3, 8'hFF);
        pin[4] = 1'b1; tick(1);
        pin[4] = 1'b0; tick(4);
        rd(2'd3, d); chk("R12 short pulse caught", {7'd0, d[4]}, 8'h01);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule